// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits between a processor-side bus master port and a memory or peripheral slave port. Two 32 MB alias windows are decoded on the master side. Each 4-byte-aligned word in a window stands for exactly one bit of a 1 MB primary region. A read of such a word becomes a single downstream read, and the selected bit comes back zero-extended. A write becomes a locked read-modify-write of the primary word: bit 0 of the write data sets or clears the selected bit.

Accesses outside both windows reach the slave port with no change and no added cycle. Alias accesses get an error response and never reach the slave in two cases: the requesting master is not the core, or the address is not word-aligned.

The bus on both sides uses a simple request/ready scheme. A request holds its fields until the cycle in which ready is high, and an error flag is valid in that same cycle.

Top module: `bitband_unit`

## Requirements
- R1: An address outside both alias windows is forwarded combinationally: sReq, sWrite, sAddr and sWdata equal the master fields, and mReady, mErr and mRdata equal sReady, sErr and sRdata in the same cycle. sLock is 0.
- R2: The memory window is 0x2200_0000 to 0x23FF_FFFF, and its primary base is 0x2000_0000. With off = addr − 0x2200_0000 and n = off >> 2, the downstream access uses word address base + ((n >> 5) << 2), and the bit is n[4:0] of the 32-bit little-endian word.
- R3: The peripheral window is 0x4200_0000 to 0x43FF_FFFF. It maps in the same way onto the primary base 0x4000_0000, including the last bit at alias 0x43FF_FFFC, which is bit 31 of word 0x400F_FFFC.
- R4: An alias read performs exactly one downstream read and no write. It returns the selected bit in mRdata[0], with mRdata[31:1] = 0.
- R5: An alias write reads the primary word and then writes it back to the same address. The selected bit is set when mWdata[0] = 1 and cleared when it is 0, and all other bits are unchanged.
- R6: sLock is high in every downstream phase of an alias write, both the read and the write. It is low for alias reads and for pass-through accesses.
- R7: An alias access whose mId differs from the core ID (default 0) makes no downstream access. It completes with mErr = 1 one cycle after it is presented.
- R8: A non-word-aligned alias address (addr[1:0] ≠ 0) is treated in the same way as R7.
- R9: A downstream error in the read phase ends the sequence with no write and returns mErr = 1. A downstream error in the write phase also returns mErr = 1.
- R10: For an alias access, mReady stays low until the cycle after the last downstream phase completes, and is then high for exactly one cycle. With zero downstream wait states, a read completes in 3 cycles and a write in 4 cycles. mRdata is 0 in the response to an alias write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mReq | input | 1 | Master request valid |
| mWrite | input | 1 | Master write (1) or read (0) |
| mAddr | input | 32 | Master byte address |
| mWdata | input | 32 | Master write data |
| mId | input | 4 | Requesting master identifier |
| mRdata | output | 32 | Read data to master |
| mReady | output | 1 | Master access completes this cycle |
| mErr | output | 1 | Error response, valid with mReady |
| sReq | output | 1 | Slave request valid |
| sWrite | output | 1 | Slave write (1) or read (0) |
| sLock | output | 1 | Locked read-modify-write in progress |
| sAddr | output | 32 | Slave byte address |
| sWdata | output | 32 | Slave write data |
| sRdata | input | 32 | Slave read data |
| sReady | input | 1 | Slave access completes this cycle |
| sErr | input | 1 | Slave error, valid with sReady |

## Verification
The bench builds the unit with its default parameters: both window bases as listed above, a 32 MB alias span, 4-bit master IDs and core ID 0. Every nonzero ID is therefore a foreign master, so the error path of R7 is reached often in random traffic. The 25-bit alias span makes the last word of the peripheral window reachable, and that word maps onto the top bit of the last primary word. The slave model inserts 0 to 3 random wait states and can inject errors in either phase, which exercises lock continuity and early termination.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } bbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic aliasMode;  // datapath drives ports from its own registers
    logic latchReq;   // capture translated request
    logic drvReq;     // downstream request
    logic drvWrite;   // downstream write
    logic lock;       // downstream lock
    logic capRead;    // capture read-phase data and error
    logic capWrErr;   // capture write-phase error
    logic respond;    // upstream ready pulse
  } bbStrobe_t;

endpackage

// File: rtl/bitband_ctrl.sv
module bitband_ctrl
  import bitband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mReq,
  input  logic      mWrite,
  input  logic      aliasHit,
  input  logic      aliasBad,
  input  logic      sReady,
  input  logic      sErr,
  output bbStrobe_t strb
);

  bbState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (mReq && aliasHit) begin
          strb.aliasMode = 1'b1;
          strb.latchReq  = 1'b1;
          stateNext      = aliasBad ? ST_RESP : ST_READ;
        end
      end
      ST_READ: begin
        strb.aliasMode = 1'b1;
        strb.drvReq    = 1'b1;
        strb.lock      = mWrite;
        if (sReady) begin
          strb.capRead = 1'b1;
          stateNext    = (sErr || !mWrite) ? ST_RESP : ST_WRITE;
        end
      end
      ST_WRITE: begin
        strb.aliasMode = 1'b1;
        strb.drvReq    = 1'b1;
        strb.drvWrite  = 1'b1;
        strb.lock      = 1'b1;
        if (sReady) begin
          strb.capWrErr = 1'b1;
          stateNext     = ST_RESP;
        end
      end
      ST_RESP: begin
        strb.aliasMode = 1'b1;
        strb.respond   = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE) |-> $past(strb.lock));

  // R9
  rd_err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && sReady && sErr) |=> (state == ST_RESP));

  // R7
  bad_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && mReq && aliasHit && aliasBad) |=> (state == ST_RESP));

  // R10
  resp_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESP) |=> (state == ST_IDLE));

endmodule

// File: rtl/bitband_datapath.sv
module bitband_datapath
  import bitband_pkg::*;
#(
  parameter int               ADDR_W          = 32,
  parameter int               DATA_W          = 32,
  parameter int               ID_W            = 4,
  parameter logic [ID_W-1:0]  CORE_ID         = '0,
  parameter int               ALIAS_SPAN_LOG2 = 25,
  parameter logic [ADDR_W-1:0] MEM_ALIAS_BASE = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] MEM_PRIM_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] PER_ALIAS_BASE = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] PER_PRIM_BASE  = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbStrobe_t         strb,
  input  logic              mReq,
  input  logic              mWrite,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mWdata,
  input  logic [ID_W-1:0]   mId,
  output logic [DATA_W-1:0] mRdata,
  output logic              mReady,
  output logic              mErr,
  output logic              sReq,
  output logic              sWrite,
  output logic              sLock,
  output logic [ADDR_W-1:0] sAddr,
  output logic [DATA_W-1:0] sWdata,
  input  logic [DATA_W-1:0] sRdata,
  input  logic              sReady,
  input  logic              sErr,
  output logic              aliasHit,
  output logic              aliasBad
);

  localparam int WORD_LSB  = $clog2(DATA_W / 8);
  localparam int BIT_IDX_W = $clog2(DATA_W);
  localparam int NUM_W     = ALIAS_SPAN_LOG2 - WORD_LSB;
  localparam int OFF_W     = NUM_W - BIT_IDX_W + WORD_LSB;

  logic                 hitMem, hitPer;
  logic [NUM_W-1:0]     bitNum;
  logic [ADDR_W-1:0]    primOffset, primAddr;

  assign hitMem = mAddr[ADDR_W-1:ALIAS_SPAN_LOG2] == MEM_ALIAS_BASE[ADDR_W-1:ALIAS_SPAN_LOG2];
  assign hitPer = mAddr[ADDR_W-1:ALIAS_SPAN_LOG2] == PER_ALIAS_BASE[ADDR_W-1:ALIAS_SPAN_LOG2];
  assign aliasHit = hitMem || hitPer;
  assign aliasBad = (mAddr[WORD_LSB-1:0] != '0) || (mId != CORE_ID);

  assign bitNum     = mAddr[ALIAS_SPAN_LOG2-1:WORD_LSB];
  assign primOffset = ADDR_W'({bitNum[NUM_W-1:BIT_IDX_W], {WORD_LSB{1'b0}}});
  assign primAddr   = (hitPer ? PER_PRIM_BASE : MEM_PRIM_BASE) + primOffset;

  logic [ADDR_W-1:0]    primAddrQ;
  logic [BIT_IDX_W-1:0] bitPosQ;
  logic                 setQ, writeQ, bitQ, errQ;
  logic [DATA_W-1:0]    wordQ, bitMask;

  assign bitMask = DATA_W'(1) << bitPosQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primAddrQ <= '0;
      bitPosQ   <= '0;
      setQ      <= 1'b0;
      writeQ    <= 1'b0;
      bitQ      <= 1'b0;
      errQ      <= 1'b0;
      wordQ     <= '0;
    end else begin
      if (strb.latchReq) begin
        primAddrQ <= primAddr;
        bitPosQ   <= bitNum[BIT_IDX_W-1:0];
        setQ      <= mWdata[0];
        writeQ    <= mWrite;
        bitQ      <= 1'b0;
        errQ      <= aliasBad;
      end
      if (strb.capRead) begin
        bitQ  <= sRdata[bitPosQ];
        wordQ <= setQ ? (sRdata | bitMask) : (sRdata & ~bitMask);
        errQ  <= sErr;
      end
      if (strb.capWrErr) errQ <= sErr;
    end
  end

  always_comb begin
    if (strb.aliasMode) begin
      sReq   = strb.drvReq;
      sWrite = strb.drvWrite;
      sLock  = strb.lock;
      sAddr  = primAddrQ;
      sWdata = wordQ;
      mReady = strb.respond;
      mErr   = strb.respond && errQ;
      mRdata = DATA_W'(bitQ && !writeQ);
    end else begin
      sReq   = mReq;
      sWrite = mWrite;
      sLock  = 1'b0;
      sAddr  = mAddr;
      sWdata = mWdata;
      mReady = sReady;
      mErr   = sErr;
      mRdata = sRdata;
    end
  end

  // R5
  rmw_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.capRead) && writeQ) |-> ($countones(wordQ ^ $past(sRdata)) <= 1));

endmodule

// File: rtl/bitband_unit.sv
module bitband_unit
  import bitband_pkg::*;
#(
  parameter int               ADDR_W          = 32,
  parameter int               DATA_W          = 32,
  parameter int               ID_W            = 4,
  parameter logic [ID_W-1:0]  CORE_ID         = '0,
  parameter int               ALIAS_SPAN_LOG2 = 25,
  parameter logic [ADDR_W-1:0] MEM_ALIAS_BASE = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] MEM_PRIM_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] PER_ALIAS_BASE = 32'h4200_0000,
  parameter logic [ADDR_W-1:0] PER_PRIM_BASE  = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mReq,
  input  logic              mWrite,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [DATA_W-1:0] mWdata,
  input  logic [ID_W-1:0]   mId,
  output logic [DATA_W-1:0] mRdata,
  output logic              mReady,
  output logic              mErr,
  output logic              sReq,
  output logic              sWrite,
  output logic              sLock,
  output logic [ADDR_W-1:0] sAddr,
  output logic [DATA_W-1:0] sWdata,
  input  logic [DATA_W-1:0] sRdata,
  input  logic              sReady,
  input  logic              sErr
);

  bbStrobe_t strb;
  logic      aliasHit, aliasBad;

  bitband_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .mReq     (mReq),
    .mWrite   (mWrite),
    .aliasHit (aliasHit),
    .aliasBad (aliasBad),
    .sReady   (sReady),
    .sErr     (sErr),
    .strb     (strb)
  );

  bitband_datapath #(
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .ID_W            (ID_W),
    .CORE_ID         (CORE_ID),
    .ALIAS_SPAN_LOG2 (ALIAS_SPAN_LOG2),
    .MEM_ALIAS_BASE  (MEM_ALIAS_BASE),
    .MEM_PRIM_BASE   (MEM_PRIM_BASE),
    .PER_ALIAS_BASE  (PER_ALIAS_BASE),
    .PER_PRIM_BASE   (PER_PRIM_BASE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mReq     (mReq),
    .mWrite   (mWrite),
    .mAddr    (mAddr),
    .mWdata   (mWdata),
    .mId      (mId),
    .mRdata   (mRdata),
    .mReady   (mReady),
    .mErr     (mErr),
    .sReq     (sReq),
    .sWrite   (sWrite),
    .sLock    (sLock),
    .sAddr    (sAddr),
    .sWdata   (sWdata),
    .sRdata   (sRdata),
    .sReady   (sReady),
    .sErr     (sErr),
    .aliasHit (aliasHit),
    .aliasBad (aliasBad)
  );

endmodule

// File: tb/bitband_unit_tb_top.sv
module bitband_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mReq = 1'b0, mWrite = 1'b0;
  logic [31:0] mAddr = '0, mWdata = '0;
  logic [3:0]  mId = '0;
  logic [31:0] mRdata;
  logic        mReady, mErr;
  logic        sReq, sWrite, sLock;
  logic [31:0] sAddr, sWdata;
  logic [31:0] sRdataR = '0;
  logic        sReadyR = 1'b0, sErrR = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitband_unit dut_i (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite), .mAddr(mAddr),
    .mWdata(mWdata), .mId(mId), .mRdata(mRdata), .mReady(mReady), .mErr(mErr),
    .sReq(sReq), .sWrite(sWrite), .sLock(sLock), .sAddr(sAddr), .sWdata(sWdata),
    .sRdata(sRdataR), .sReady(sReadyR), .sErr(sErrR)
  );

  int errors = 0, checks = 0;
  int rdCnt = 0, wrCnt = 0, lockBad = 0;
  int waitCnt = 0, maxWait = 0, errMode = 0;
  logic expectLock = 1'b0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_96E1;
  endfunction

  // 0 = pass-through, 1 = memory window, 2 = peripheral window
  function automatic int kindOf(input logic [31:0] a);
    if (a[31:25] == 7'h11) return 1;
    if (a[31:25] == 7'h21) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] primWordOf(input logic [31:0] a);
    logic [31:0] base = (kindOf(a) == 2) ? 32'h4000_0000 : 32'h2000_0000;
    return base + {9'd0, a[24:7], 5'd0} / 8;
  endfunction

  function automatic int bitOf(input logic [31:0] a);
    return int'(a[6:2]);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Slave model: evaluates just after each falling edge
  always @(negedge clk) begin
    #1;
    if (sReq) begin
      if (waitCnt == 0) begin
        sReadyR = 1'b1;
        sRdataR = memRead(sAddr);
        sErrR   = (errMode == 1 && !sWrite) || (errMode == 2 && sWrite);
        if (sWrite) begin
          wrCnt++;
          if (!sErrR) mem[sAddr] = sWdata;
        end else rdCnt++;
        if (sLock !== expectLock) lockBad++;
        waitCnt = (maxWait == 0) ? 0 : int'($urandom_range(maxWait, 0));
      end else begin
        waitCnt--;
        sReadyR = 1'b0;
        sErrR   = 1'b0;
      end
    end else begin
      sReadyR = 1'b0;
      sErrR   = 1'b0;
    end
  end

  // Called just after a falling edge
  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] id, output logic [31:0] rd, output logic er,
                        output int cyc);
    mReq = 1'b1; mWrite = wr; mAddr = addr; mWdata = wd; mId = id; cyc = 0;
    forever begin
      #2;
      if (mReady) break;
      cyc++;
      if (cyc > 60) break;
      @(negedge clk);
    end
    rd = mRdata; er = mErr;
    if (cyc > 60) check(1'b0, "R10", "access watchdog", 32'(cyc), 32'd0);
    @(negedge clk);
    mReq = 1'b0;
  endtask

  task automatic aliasRead(input logic [31:0] a, input string req, input int expCyc);
    logic [31:0] rd; logic er; int cyc, r0, w0;
    logic [31:0] expBit = 32'((memRead(primWordOf(a)) >> bitOf(a)) & 1);
    expectLock = 1'b0; r0 = rdCnt; w0 = wrCnt;
    access(1'b0, a, 32'hFFFF_FFFF, 4'd0, rd, er, cyc);
    check(rd == expBit, req, "alias read bit (R4)", rd, expBit);
    check(!er, req, "alias read err", 32'(er), 0);
    check(rdCnt - r0 == 1 && wrCnt == w0, "R4", "one read no write", 32'(rdCnt - r0), 1);
    if (expCyc >= 0) check(cyc == expCyc, "R10", "alias read latency", 32'(cyc), 32'(expCyc));
  endtask

  task automatic aliasWrite(input logic [31:0] a, input logic v, input string req, input int expCyc);
    logic [31:0] rd; logic er; int cyc, w0;
    logic [31:0] old = memRead(primWordOf(a));
    logic [31:0] exp = v ? (old | (32'd1 << bitOf(a))) : (old & ~(32'd1 << bitOf(a)));
    expectLock = 1'b1; w0 = wrCnt; lockBad = 0;
    access(1'b1, a, {31'h1234_567, v}, 4'd0, rd, er, cyc);
    expectLock = 1'b0;
    check(memRead(primWordOf(a)) == exp, req, "RMW result (R5)", memRead(primWordOf(a)), exp);
    check(wrCnt - w0 == 1 && !er, "R5", "one write no err", 32'(wrCnt - w0), 1);
    check(lockBad == 0, "R6", "lock during RMW", 32'(lockBad), 0);
    check(rd == 0, "R10", "write response data", rd, 0);
    if (expCyc >= 0) check(cyc == expCyc, "R10", "alias write latency", 32'(cyc), 32'(expCyc));
  endtask

  task automatic badAccess(input logic wr, input logic [31:0] a, input logic [3:0] id, input string req);
    logic [31:0] rd; logic er; int cyc, r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    access(wr, a, 32'h1, id, rd, er, cyc);
    check(er, req, "error response", 32'(er), 1);
    check(rdCnt == r0 && wrCnt == w0, req, "no downstream access", 32'(rdCnt - r0 + wrCnt - w0), 0);
    check(cyc == 1, req, "error latency", 32'(cyc), 1);
  endtask

  task automatic passAccess(input logic wr, input logic [31:0] a, input logic [31:0] wd, input int expCyc);
    logic [31:0] rd; logic er; int cyc;
    logic [31:0] exp = memRead(a);
    expectLock = 1'b0; lockBad = 0;
    access(wr, a, wd, 4'($urandom_range(15, 0)), rd, er, cyc);
    if (wr) check(memRead(a) == wd, "R1", "pass-through write", memRead(a), wd);
    else    check(rd == exp, "R1", "pass-through read", rd, exp);
    check(!er && lockBad == 0, "R1", "pass-through err/lock", 32'(lockBad), 0);
    if (expCyc >= 0) check(cyc == expCyc, "R1", "pass-through latency", 32'(cyc), 32'(expCyc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R10", "global watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, w0tmp; logic er; int cyc, wc;
    void'($urandom(32'h1BB5));
    repeat (3) @(negedge clk);
    #2;
    check(!mReady && !sReq && !sLock, "R1", "reset state", {29'd0, mReady, sReq, sLock}, 0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);

    // Directed, zero wait states
    mem[32'h2000_0100] = 32'hDEAD_0001;
    passAccess(1'b0, 32'h2000_0100, 0, 0);
    passAccess(1'b1, 32'h21FF_FFFC, 32'h0BAD_F00D, 0);
    passAccess(1'b0, 32'h4400_0000, 0, 0);
    mem[32'h2000_0010] = 32'h0000_0100;
    aliasRead(32'h2200_0220, "R2", 2);
    aliasWrite(32'h2200_020C, 1'b1, "R2", 3);
    check(mem[32'h2000_0010] == 32'h0000_0108, "R5", "set bit 3", mem[32'h2000_0010], 32'h108);
    aliasWrite(32'h2200_0220, 1'b0, "R5", 3);
    check(mem[32'h2000_0010] == 32'h0000_0008, "R5", "clear bit 8", mem[32'h2000_0010], 32'h8);
    mem[32'h400F_FFFC] = 32'h8000_0000;
    aliasRead(32'h43FF_FFFC, "R3", 2);
    aliasWrite(32'h43FF_FFFC, 1'b0, "R3", 3);
    check(mem[32'h400F_FFFC] == 0, "R3", "top bit cleared", mem[32'h400F_FFFC], 0);
    aliasWrite(32'h4200_0004, 1'b1, "R3", 3);
    badAccess(1'b0, 32'h2200_0004, 4'd5, "R7");
    badAccess(1'b1, 32'h4200_0010, 4'd15, "R7");
    badAccess(1'b0, 32'h2200_0222, 4'd0, "R8");
    badAccess(1'b1, 32'h4200_0001, 4'd0, "R8");

    // Downstream error in read phase: no write
    errMode = 1; expectLock = 1'b1; wc = wrCnt; w0tmp = memRead(32'h2000_0010);
    access(1'b1, 32'h2200_0200, 32'h1, 4'd0, rd, er, cyc);
    check(er && wrCnt == wc, "R9", "read-phase error stops RMW", 32'(wrCnt - wc), 0);
    check(memRead(32'h2000_0010) == w0tmp, "R9", "word unchanged", memRead(32'h2000_0010), w0tmp);
    // Downstream error in write phase
    errMode = 2; wc = wrCnt;
    access(1'b1, 32'h2200_0200, 32'h1, 4'd0, rd, er, cyc);
    check(er && wrCnt == wc + 1, "R9", "write-phase error returned", 32'(er), 1);
    errMode = 0; expectLock = 1'b0;
    access(1'b0, 32'h2200_0200, 32'h0, 4'd0, rd, er, cyc);
    check(!er && rd == 32'(w0tmp & 1), "R9", "state intact after errors", rd, 32'(w0tmp & 1));

    // Constrained random with wait states
    maxWait = 3;
    for (int i = 0; i < 400; i++) begin
      int sel = int'($urandom_range(9, 0));
      logic [31:0] a;
      if (sel < 3) begin
        a = 32'h2000_0000 + {20'd0, 10'($urandom_range(1023, 0)), 2'b00};
        passAccess(1'($urandom_range(1, 0)), a, $urandom(), -1);
      end else if (sel < 9) begin
        a = ((sel & 1) ? 32'h4200_0000 : 32'h2200_0000) + {17'd0, 13'($urandom_range(8191, 0)), 2'b00};
        if (sel == 8) badAccess(1'($urandom_range(1, 0)), a, 4'($urandom_range(15, 1)), "R7");
        else if (sel < 6) aliasRead(a, (sel & 1) ? "R3" : "R2", -1);
        else aliasWrite(a, 1'($urandom_range(1, 0)), (sel & 1) ? "R3" : "R2", -1);
      end else begin
        a = 32'h2200_0000 + {17'd0, 13'($urandom_range(8191, 0)), 2'($urandom_range(3, 1))};
        badAccess(1'b0, a, 4'd0, "R8");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule